// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives the six gate signals of a three-phase inverter. It has one carrier counter that all phases share. The counter can run as a triangle, counting up to the period and back down to zero, or as a sawtooth, counting up to the period and then wrapping to zero. Each phase compares the carrier with its own compare value and produces a raw level. A dead-time stage then splits the raw level into a high-side output and a low-side output. On each switch, the side that is turning on must wait a programmable number of clock cycles. Because of this wait, the two switches of a leg are never on at the same time.

Software writes the period and the three compare values into buffer inputs. The active copies take those values only at a fixed carrier point. This allows the values to change while the carrier is running without producing a torn cycle. The block flags the carrier peak and the carrier valley, and it emits two converter-start strobes at programmable carrier positions. A fault can arrive on an asynchronous pin or as a synchronous event. Either one pulls all six outputs low at once, and they stay low until software clears the latched fault.

The period must be at least 1. The run input must be low for at least one cycle after reset so that the buffers are copied before the carrier starts. The carrier mode may only be changed while run is low.

Top module: `pwm3_gen`

## Requirements
- R1: After reset the carrier is 0 and counting up, and every output (`pwm_hi`, `pwm_lo`, `irq_peak`, `irq_valley`, `adc_trg_a`, `adc_trg_b`, `tripped`) is 0.
- R2: Triangle mode (`saw_mode`=0) works as follows:
  - The carrier steps by one per clock, from 0 up to the active period P and back down to 0.
  - `irq_peak` is high in the single cycle where the carrier equals P while rising.
  - `irq_valley` is high in the single cycle where the carrier equals 0 while falling.
- R3: Sawtooth mode (`saw_mode`=1) works as follows:
  - The carrier counts 0, 1, …, P and then returns to 0.
  - `irq_peak` is high in the cycle where the carrier equals P.
  - `irq_valley` is never asserted.
- R4: The raw level of phase k is 1 when the carrier is below the active compare value of that phase (`cmp_buf[16k+15:16k]` with the default width). A compare of 0 therefore keeps the leg low, and a compare above P keeps it high.
- R5: The active period and compare values are copied from the buffer inputs at these points, and at no other time:
  - at the valley cycle in triangle mode;
  - at the peak cycle in sawtooth mode;
  - on every cycle while `run` is 0.
  A buffer write made between these points has no effect until the next one.
- R6: Each raw level is registered once. A side of the pair turns on only after the registered level has held its new value for `dead_cyc` further cycles. If the level flips back before that count is reached, both outputs of the pair stay 0.
- R7: `pwm_hi[k]` and `pwm_lo[k]` are never 1 in the same cycle.
- R8: While `run` is 0, the following all hold:
  - all six outputs and all four strobes are 0;
  - the carrier is held at 0, counting up.
- R9: The asynchronous fault pin works as follows:
  - When `trip_n` goes low, all six outputs go to 0 at once, without waiting for a clock, and `tripped` goes to 1.
  - The fault stays latched after `trip_n` returns high. It clears only on a clock with `trip_clr`=1, `trip_n`=1 and `trip_sync`=0.
- R10: A clock with `trip_sync`=1 sets `tripped` in the same way. `trip_sync` takes priority over `trip_clr`.
- R11: Each converter strobe (`adc_trg_a` and `adc_trg_b`) goes high in a cycle where the carrier equals that strobe's compare input. In triangle mode the strobe's direction bit also decides:
  - bit = 0: the strobe fires only while the carrier is rising;
  - bit = 1: the strobe fires only while the carrier is falling.
  In sawtooth mode the direction bit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Carrier enable |
| saw_mode | input | 1 | 1 = sawtooth carrier, 0 = triangle carrier |
| prd_buf | input | CW | Buffered carrier period |
| cmp_buf | input | NPH*CW | Buffered compare values, phase k in bits [k*CW +: CW] |
| dead_cyc | input | DW | Dead time in clock cycles |
| trg_a_at | input | CW | Carrier value for strobe A |
| trg_b_at | input | CW | Carrier value for strobe B |
| trg_a_fall | input | 1 | Strobe A direction in triangle mode (1 = falling) |
| trg_b_fall | input | 1 | Strobe B direction in triangle mode (1 = falling) |
| trip_n | input | 1 | Asynchronous fault, active low |
| trip_sync | input | 1 | Synchronous fault event |
| trip_clr | input | 1 | Clears the latched fault |
| pwm_hi | output | NPH | High-side outputs |
| pwm_lo | output | NPH | Low-side outputs |
| irq_peak | output | 1 | Carrier peak strobe |
| irq_valley | output | 1 | Carrier valley strobe |
| adc_trg_a | output | 1 | Converter start strobe A |
| adc_trg_b | output | 1 | Converter start strobe B |
| tripped | output | 1 | Latched fault flag |

## Verification
The carrier is run in triangle mode with three different compare values per phase, covering a low value, a middle value and a value above the period. This separates the "below compare" rule from its off-by-one neighbours and exercises the stuck-high and stuck-low legs.

Buffer writes are made in the middle of a carrier period, once per mode. Any copy made at the wrong carrier point moves the pulse edges visibly.

A compare value of 1 combined with a dead time of 3 produces a pulse shorter than the dead time. This pulse must leave both outputs of the pair silent. Runs with zero dead time show the opposite case.

The fault is exercised in three ways:
- an asynchronous drop between clock edges;
- a clear attempted while the fault pin is still low;
- a synchronous event arriving together with a clear.

These show whether the latch and its priority are right. A minimum-period triangle checks the turnaround corner.

// File: rtl/pwm3_gen.sv
module pwm3_gen #(
  parameter int CW  = 16,
  parameter int DW  = 8,
  parameter int NPH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              saw_mode,
  input  logic [CW-1:0]     prd_buf,
  input  logic [NPH*CW-1:0] cmp_buf,
  input  logic [DW-1:0]     dead_cyc,
  input  logic [CW-1:0]     trg_a_at,
  input  logic [CW-1:0]     trg_b_at,
  input  logic              trg_a_fall,
  input  logic              trg_b_fall,
  input  logic              trip_n,
  input  logic              trip_sync,
  input  logic              trip_clr,
  output logic [NPH-1:0]    pwm_hi,
  output logic [NPH-1:0]    pwm_lo,
  output logic              irq_peak,
  output logic              irq_valley,
  output logic              adc_trg_a,
  output logic              adc_trg_b,
  output logic              tripped
);

  logic [CW-1:0]     cnt;
  logic [CW-1:0]     prd_act;
  logic [NPH*CW-1:0] cmp_act;
  logic              dir_up;
  logic              load_pt;

  wire at_top = (cnt == prd_act);
  wire at_bot = (cnt == '0);

  assign irq_peak   = run && at_top && (saw_mode || dir_up);
  assign irq_valley = run && !saw_mode && at_bot && !dir_up;
  assign load_pt    = !run || (saw_mode ? irq_peak : irq_valley);

  assign adc_trg_a = run && (cnt == trg_a_at) && (saw_mode || (dir_up != trg_a_fall));
  assign adc_trg_b = run && (cnt == trg_b_at) && (saw_mode || (dir_up != trg_b_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (!run) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (saw_mode) begin
      cnt    <= at_top ? '0 : cnt + 1'b1;
      dir_up <= 1'b1;
    end else if (dir_up) begin
      if (at_top) begin
        cnt    <= cnt - 1'b1;
        dir_up <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (at_bot) begin
        cnt    <= cnt + 1'b1;
        dir_up <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_act <= '0;
      cmp_act <= '0;
    end else if (load_pt) begin
      prd_act <= prd_buf;
      cmp_act <= cmp_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n or negedge trip_n) begin
    if (!rst_n)         tripped <= 1'b0;
    else if (!trip_n)   tripped <= 1'b1;
    else if (trip_sync) tripped <= 1'b1;
    else if (trip_clr)  tripped <= 1'b0;
  end

  for (genvar k = 0; k < NPH; k++) begin : g_leg
    logic          lvl;
    logic [DW-1:0] age;
    wire raw = (cnt < cmp_act[k*CW +: CW]);
    wire ok  = run && !tripped && (age >= dead_cyc);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl <= 1'b0;
        age <= '0;
      end else if (raw != lvl) begin
        lvl <= raw;
        age <= '0;
      end else if (age != '1) begin
        age <= age + 1'b1;
      end
    end

    assign pwm_hi[k] = ok && lvl;
    assign pwm_lo[k] = ok && !lvl;
  end

endmodule

// File: rtl/pwm3_gen_chk.sv
module pwm3_gen_chk #(
  parameter int CW  = 16,
  parameter int DW  = 8,
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic           saw_mode,
  input logic [DW-1:0]  dead_cyc,
  input logic           trip_sync,
  input logic           trip_clr,
  input logic [NPH-1:0] pwm_hi,
  input logic [NPH-1:0] pwm_lo,
  input logic           irq_peak,
  input logic           irq_valley,
  input logic           tripped,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  prd_act,
  input logic           load_pt
);

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= prd_act);

  p_peak_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_peak && !saw_mode) |=> (!run || cnt == $past(cnt) - 1'b1));

  p_valley_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valley |=> (!run || saw_mode || cnt == 1));

  p_saw_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_peak && saw_mode) |=> cnt == '0);

  p_buf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load_pt) |=> $stable(prd_act));

  p_trip_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !trip_clr) |=> tripped);

  p_trip_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> (pwm_hi == '0 && pwm_lo == '0));

  p_sync_trip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trip_sync |=> tripped);

  for (genvar k = 0; k < NPH; k++) begin : g_dt
    p_gap_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwm_hi[k]) && dead_cyc != '0 && $stable(dead_cyc)) |-> !$past(pwm_lo[k]));
    p_gap_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwm_lo[k]) && dead_cyc != '0 && $stable(dead_cyc)) |-> !$past(pwm_hi[k]));
  end

endmodule

bind pwm3_gen pwm3_gen_chk #(.CW(CW), .DW(DW), .NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .saw_mode(saw_mode), .dead_cyc(dead_cyc),
  .trip_sync(trip_sync), .trip_clr(trip_clr), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
  .irq_peak(irq_peak), .irq_valley(irq_valley), .tripped(tripped),
  .cnt(cnt), .prd_act(prd_act), .load_pt(load_pt)
);

// File: tb/test_pwm3_gen.sv
module test_pwm3_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, saw_mode = 1'b0;
  logic [15:0] prd_buf = 16'd8;
  logic [47:0] cmp_buf = {16'd9, 16'd5, 16'd2};
  logic [7:0]  dead_cyc = 8'd2;
  logic [15:0] trg_a_at = 16'd3, trg_b_at = 16'd6;
  logic        trg_a_fall = 1'b0, trg_b_fall = 1'b1;
  logic        trip_n = 1'b1, trip_sync = 1'b0, trip_clr = 1'b0;
  logic [2:0]  pwm_hi, pwm_lo;
  logic        irq_peak, irq_valley, adc_trg_a, adc_trg_b, tripped;

  int n_cmp = 0, n_bad = 0, n_cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm3_gen i_pwm3_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .saw_mode(saw_mode), .prd_buf(prd_buf),
    .cmp_buf(cmp_buf), .dead_cyc(dead_cyc), .trg_a_at(trg_a_at), .trg_b_at(trg_b_at),
    .trg_a_fall(trg_a_fall), .trg_b_fall(trg_b_fall), .trip_n(trip_n),
    .trip_sync(trip_sync), .trip_clr(trip_clr), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .irq_peak(irq_peak), .irq_valley(irq_valley), .adc_trg_a(adc_trg_a),
    .adc_trg_b(adc_trg_b), .tripped(tripped)
  );

  // behavioural reference
  int m_cnt = 0, m_prd = 0;
  bit m_up = 1;
  int m_cmp[3] = '{0, 0, 0};
  bit m_lvl[3] = '{0, 0, 0};
  int m_age[3] = '{0, 0, 0};
  bit m_trip = 0;

  always @(posedge clk) begin
    bit pk, vl, ld, r;
    int ncnt;
    bit nup;
    n_cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_prd = 0; m_trip = 0;
      foreach (m_cmp[k]) begin m_cmp[k] = 0; m_lvl[k] = 0; m_age[k] = 0; end
    end else begin
      pk = run && m_cnt == m_prd && (saw_mode || m_up);
      vl = run && !saw_mode && m_cnt == 0 && !m_up;
      ld = !run || (saw_mode ? pk : vl);
      foreach (m_cmp[k]) begin
        r = (m_cnt < m_cmp[k]);
        if (r != m_lvl[k]) begin m_lvl[k] = r; m_age[k] = 0; end
        else if (m_age[k] < 255) m_age[k]++;
      end
      if (!run)          begin ncnt = 0; nup = 1; end
      else if (saw_mode) begin ncnt = pk ? 0 : m_cnt + 1; nup = 1; end
      else if (m_up)     begin
        if (m_cnt == m_prd) begin ncnt = m_cnt - 1; nup = 0; end
        else begin ncnt = m_cnt + 1; nup = 1; end
      end else begin
        if (m_cnt == 0) begin ncnt = 1; nup = 1; end
        else begin ncnt = m_cnt - 1; nup = 0; end
      end
      m_cnt = ncnt; m_up = nup;
      if (ld) begin
        m_prd = prd_buf;
        foreach (m_cmp[k]) m_cmp[k] = cmp_buf[k*16 +: 16];
      end
      if (!trip_n)        m_trip = 1;
      else if (trip_sync) m_trip = 1;
      else if (trip_clr)  m_trip = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit te, ok;
    logic [2:0] ehi, elo;
    te = m_trip || !trip_n;
    for (int k = 0; k < 3; k++) begin
      ok = run && !te && (m_age[k] >= dead_cyc);
      ehi[k] = ok && m_lvl[k];
      elo[k] = ok && !m_lvl[k];
    end
    if (!rst_n) begin
      chk("R1 pwm_hi", pwm_hi, 0);
      chk("R1 pwm_lo", pwm_lo, 0);
      chk("R1 strobes", {irq_peak, irq_valley, adc_trg_a, adc_trg_b}, 0);
      chk("R1 tripped", tripped, 0);
    end else begin
      chk("R4 R5 R6 R8 R9 pwm_hi", pwm_hi, ehi);
      chk("R4 R5 R6 R8 R9 pwm_lo", pwm_lo, elo);
      chk("R7 pair overlap", pwm_hi & pwm_lo, 0);
      chk("R2 R3 R8 irq_peak", irq_peak, run && m_cnt == m_prd && (saw_mode || m_up));
      chk("R2 R3 R8 irq_valley", irq_valley, run && !saw_mode && m_cnt == 0 && !m_up);
      chk("R11 adc_trg_a", adc_trg_a,
          run && m_cnt == trg_a_at && (saw_mode || (m_up != trg_a_fall)));
      chk("R11 adc_trg_b", adc_trg_b,
          run && m_cnt == trg_b_at && (saw_mode || (m_up != trg_b_fall)));
      chk("R9 R10 tripped", tripped, te);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;
    step(3);
    run = 1'b1;                                   // R2 triangle, R4 compares 2/5/9
    step(45);
    cmp_buf = {16'd0, 16'd7, 16'd4}; prd_buf = 16'd10;   // R5 mid-period write
    step(50);
    dead_cyc = 8'd0;                              // R6 zero dead time
    step(30);
    cmp_buf = {16'd11, 16'd6, 16'd1}; dead_cyc = 8'd3;   // R6 short pulse
    step(50);
    run = 1'b0;                                   // R8
    step(5);
    saw_mode = 1'b1; prd_buf = 16'd6; cmp_buf = {16'd7, 16'd3, 16'd1};
    dead_cyc = 8'd1; trg_a_at = 16'd6; trg_a_fall = 1'b1; trg_b_at = 16'd0;
    step(1);
    run = 1'b1;                                   // R3 sawtooth, R11
    step(40);
    cmp_buf = {16'd2, 16'd4, 16'd6};              // R5 in sawtooth
    step(30);
    @(posedge clk); #5 trip_n = 1'b0;             // R9 asynchronous drop
    step(3);
    trip_clr = 1'b1; step(2);                     // R9 clear ignored while low
    trip_clr = 1'b0; trip_n = 1'b1; step(4);
    trip_clr = 1'b1; step(1);
    trip_clr = 1'b0; step(10);
    trip_sync = 1'b1; step(1);                    // R10
    trip_sync = 1'b0; step(5);
    trip_clr = 1'b1; trip_sync = 1'b1; step(1);   // R10 priority
    trip_sync = 1'b0; step(1);
    trip_clr = 1'b0; step(10);
    run = 1'b0; step(3);
    saw_mode = 1'b0; prd_buf = 16'd1; cmp_buf = {16'd2, 16'd1, 16'd0};
    trg_a_at = 16'd1; trg_a_fall = 1'b0; trg_b_at = 16'd0; trg_b_fall = 1'b1;
    dead_cyc = 8'd0; step(1);
    run = 1'b1;                                   // R2 minimum period
    step(20);
    run = 1'b0;
    step(5);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && n_cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule